// File: doc/BRIEF.md
# Conversion Word Serial Readout

This block keeps the most recent 24-bit conversion result and presents it on a single output pin. That pin carries both the ready indication and the data. A result-valid strobe loads a new word. While the chip-enable input is high, the pin then drops low to show that a word is waiting. An external reader toggles a serial clock, and the block shifts the word out most significant bit first, one bit for each rising edge.

The serial clock arrives from outside the system clock domain. A two-flop synchronizer brings it into that domain, and a further register detects its rising and falling edges. A small state machine tracks the read.

The states are:
- `ST_EMPTY`: no unread word; the pin is high.
- `ST_ARMED`: a word is waiting; the pin is low when chip-enable is high.
- `ST_SHIFT`: bits are being presented.

The transitions are:
- load: any state to `ST_ARMED` on a result strobe.
- first rise: `ST_ARMED` to `ST_SHIFT`.
- step: `ST_SHIFT` to `ST_SHIFT` on each later rise, up to bit 0.
- release: `ST_SHIFT` to `ST_EMPTY` on the serial-clock fall that follows the 24th bit.

A result that arrives during a read silently replaces the held word.

Top module: `conv_word_serializer`

## Requirements
- R1: After reset the pin is high and no word is held. Serial clock edges in this condition leave it high.
- R2: From the clock edge that samples `res_valid` high, the pin is low whenever `chip_en` is 1, until the first serial-clock rise is acted on.
- R3: While `chip_en` is 0 the pin is high, in every state.
- R4: With `chip_en` at 1, successive rising edges of the serial clock present word bits 23, 22, … down to 0, where bit 23 is the sign bit of the two's-complement word. Each bit stays on the pin until the next rise.
- R5: The serial clock goes through two synchronizer flops and one edge register. The pin shows a new bit after the third system clock edge that samples `sclk_in` high, and not after the second.
- R6: After bit 0 has been presented, the next falling serial-clock edge returns the pin high. It stays high through further serial-clock edges until the next result strobe.
- R7: A result strobe in the middle of a read replaces the word and restarts the read. The pin goes low (ready), and the next rise presents bit 23 of the new word.
- R8: While `chip_en` is 0, serial-clock edges are ignored and the read position is kept. When `chip_en` returns to 1, the pin again shows the bit it showed before.
- R9: A result strobe while an earlier word is still unread replaces it. Only the newer word is shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is on `res_word` |
| res_word | input | 24 | Two's-complement conversion result |
| chip_en | input | 1 | Reader enable; active high |
| sclk_in | input | 1 | Serial clock from the reader, asynchronous to `clk` |
| dout_rdy | output | 1 | Combined pin: low means ready before the read, then carries data bits; high when idle or disabled |

## Verification
The bench goes after the edges of a read:
- The last bit and the release that follows it. A counter that is off by one would drop bit 0 or leave the pin low.
- A new result landing mid-read. A design that does not clear its position would resume partway through the new word.
- `chip_en` dropping during a read. A design that counts edges while disabled would skip bits when reading resumes.
- The synchronizer latency, checked one clock early and exactly on time. A missing or extra flop moves the bit by a cycle.
- Sign-bit and all-ones/all-zeros words. These expose a reversed bit order.

// File: rtl/conv_ser_pkg.sv
package conv_ser_pkg;

    // Read-side state of the held conversion word
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,   // nothing unread, pin idles high
        ST_ARMED = 2'd1,   // word waiting, ready shown
        ST_SHIFT = 2'd2    // bits being presented
    } rd_state_e;

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise_p,
    output logic fall_p
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sclk_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], sclk_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_p =  sync_q[STAGES-1] & ~prev_q;
    assign fall_p = ~sync_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step,
    output logic              top_bit
);

    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= load_word;
        else if (step) hold_q <= {hold_q[WORD_W-2:0], 1'b0};
    end

    assign top_bit = hold_q[WORD_W-1];

endmodule

// File: rtl/readout_fsm.sv
module readout_fsm
    import conv_ser_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_res,
    input  logic             rise_p,
    input  logic             fall_p,
    input  logic             chip_en,
    input  logic             top_bit,
    output logic             load,
    output logic             step,
    output logic             pin,
    output rd_state_e        state,
    output logic [CNT_W-1:0] bits_out
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

    rd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        step    = 1'b0;
        load    = new_res;
        if (new_res) begin
            state_d = ST_ARMED;
            cnt_d   = '0;
        end else if (chip_en) begin
            unique case (state_q)
                ST_EMPTY: ;
                ST_ARMED: begin
                    if (rise_p) begin
                        state_d = ST_SHIFT;
                        cnt_d   = CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (rise_p && cnt_q < LAST) begin
                        step  = 1'b1;
                        cnt_d = cnt_q + CNT_W'(1);
                    end else if (fall_p && cnt_q == LAST) begin
                        state_d = ST_EMPTY;
                        cnt_d   = '0;
                    end
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        if (!chip_en) begin
            pin = 1'b1;
        end else begin
            unique case (state_q)
                ST_EMPTY: pin = 1'b1;
                ST_ARMED: pin = 1'b0;
                ST_SHIFT: pin = top_bit;
                default:  pin = 1'b1;
            endcase
        end
    end

    assign state    = state_q;
    assign bits_out = cnt_q;

endmodule

// File: rtl/conv_word_serializer.sv
module conv_word_serializer
    import conv_ser_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_word,
    input  logic              chip_en,
    input  logic              sclk_in,
    output logic              dout_rdy
);

    logic             rise_p, fall_p;
    logic             load, step, top_bit;
    rd_state_e        rd_state;
    logic [CNT_W-1:0] bits_out;

    sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (res_word),
        .step      (step),
        .top_bit   (top_bit)
    );

    readout_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_res  (res_valid),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .chip_en  (chip_en),
        .top_bit  (top_bit),
        .load     (load),
        .step     (step),
        .pin      (dout_rdy),
        .state    (rd_state),
        .bits_out (bits_out)
    );

endmodule

// File: rtl/conv_word_serializer_chk.sv
module conv_word_serializer_chk
    import conv_ser_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic             chip_en,
    input logic             dout_rdy,
    input logic             rise_p,
    input logic             fall_p,
    input rd_state_e        rd_state,
    input logic [CNT_W-1:0] bits_out
);

    // R3
    assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> dout_rdy) else $error("disabled_pin_high_chk");

    // R1
    assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ST_EMPTY) |-> dout_rdy) else $error("empty_pin_high_chk");

    // R2
    assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (rd_state == ST_ARMED && bits_out == '0)) else $error("load_arms_chk");

    // R4
    assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ST_SHIFT && chip_en && !res_valid && rise_p && bits_out < CNT_W'(WORD_W))
        |=> (bits_out == $past(bits_out) + CNT_W'(1))) else $error("bit_advance_chk");

    // R4
    assert property (@(posedge clk) disable iff (!rst_n)
        bits_out <= CNT_W'(WORD_W)) else $error("count_bound_chk");

    // R6
    assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ST_SHIFT && chip_en && !res_valid && fall_p && bits_out == CNT_W'(WORD_W))
        |=> (rd_state == ST_EMPTY)) else $error("release_after_last_chk");

    // R8
    assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && !res_valid) |=> $stable(bits_out)) else $error("disabled_hold_chk");

endmodule

bind conv_word_serializer conv_word_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .chip_en   (chip_en),
    .dout_rdy  (dout_rdy),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .rd_state  (rd_state),
    .bits_out  (bits_out)
);

// File: tb/conv_word_serializer_tb.sv
module conv_word_serializer_tb;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_word = '0;
    logic         chip_en = 1'b1;
    logic         sclk_in = 1'b0;
    logic         dout_rdy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    conv_word_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_word  (res_word),
        .chip_en   (chip_en),
        .sclk_in   (sclk_in),
        .dout_rdy  (dout_rdy)
    );

    function automatic logic exp_bit(logic [W-1:0] w, int idx);
        return w[W-1-idx];
    endfunction

    task automatic check(string req, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pin=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic push(logic [W-1:0] w);
        @(negedge clk);
        res_valid = 1'b1;
        res_word  = w;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic rise_half();
        @(negedge clk);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic fall_half();
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // full read of a word, each bit checked after its rise (R4), then release (R6)
    task automatic read_all(logic [W-1:0] w, string req);
        for (int i = 0; i < W; i++) begin
            rise_half();
            check(req, dout_rdy, exp_bit(w, i));
            fall_half();
        end
        check("R6", dout_rdy, 1'b1);
        rise_half();
        check("R6", dout_rdy, 1'b1);
        fall_half();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: timeout expired=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] wa, wb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, and idle serial clock edges
        check("R1", dout_rdy, 1'b1);
        rise_half();
        check("R1", dout_rdy, 1'b1);
        fall_half();

        // R5: latency through the synchronizer
        push(24'h800001);
        check("R2", dout_rdy, 1'b0);
        @(negedge clk);
        sclk_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R5", dout_rdy, 1'b0);
        @(negedge clk);
        check("R5", dout_rdy, 1'b1);
        repeat (2) @(negedge clk);
        fall_half();
        for (int i = 1; i < W; i++) begin
            rise_half();
            check("R4", dout_rdy, exp_bit(24'h800001, i));
            fall_half();
        end
        check("R6", dout_rdy, 1'b1);

        // directed and random words
        for (int k = 0; k < 8; k++) begin
            case (k)
                0: wa = 24'h800000;
                1: wa = 24'h7FFFFF;
                2: wa = 24'hFFFFFF;
                3: wa = 24'h000000;
                default: wa = W'($urandom);
            endcase
            push(wa);
            check("R2", dout_rdy, 1'b0);
            @(negedge clk);
            chip_en = 1'b0;
            @(negedge clk);
            check("R3", dout_rdy, 1'b1);
            chip_en = 1'b1;
            @(negedge clk);
            check("R2", dout_rdy, 1'b0);
            read_all(wa, "R4");
        end

        // R7: new result mid-read restarts from its MSB
        wa = W'($urandom);
        wb = W'($urandom) | 24'h800000;
        wa[W-1] = 1'b0;
        push(wa);
        for (int i = 0; i < 5; i++) begin
            rise_half();
            check("R4", dout_rdy, exp_bit(wa, i));
            fall_half();
        end
        push(wb);
        check("R7", dout_rdy, 1'b0);
        read_all(wb, "R7");

        // R9: overwrite before any bit is read
        wa = W'($urandom);
        wb = ~wa;
        push(wa);
        repeat (3) @(negedge clk);
        push(wb);
        check("R9", dout_rdy, 1'b0);
        read_all(wb, "R9");

        // R8: chip-enable drop mid-read keeps position
        wa = W'($urandom);
        push(wa);
        for (int i = 0; i < 10; i++) begin
            rise_half();
            check("R4", dout_rdy, exp_bit(wa, i));
            fall_half();
        end
        chip_en = 1'b0;
        @(negedge clk);
        check("R3", dout_rdy, 1'b1);
        for (int i = 0; i < 3; i++) begin
            rise_half();
            check("R8", dout_rdy, 1'b1);
            fall_half();
        end
        chip_en = 1'b1;
        @(negedge clk);
        check("R8", dout_rdy, exp_bit(wa, 9));
        for (int i = 10; i < W; i++) begin
            rise_half();
            check("R8", dout_rdy, exp_bit(wa, i));
            fall_half();
        end
        check("R6", dout_rdy, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule